// File: doc/BRIEF.md
# Seedable Pseudo-Random Byte Generator

This block produces a stream of pseudo-random bytes from a maximal-length linear feedback shift register. Its state register is `STATE_W` bits wide (16 by default). Each enabled clock advances the register by one step and shows its low byte on the output. The sequence is fully deterministic, so the same starting state always gives the same bytes. This makes the block useful for test pattern generation, noise injection and repeatable stimulus.

A small sequencer picks how the state is seeded. The mode input is sampled on the last clock of reset. Reset always forces every stage to one in parallel. After that the sequencer moves into one of three states:

- `SQ_RUN`: free running.
- `SQ_WARM`: a warm-up phase that shifts ones in for `WARM_CYC` clocks.
- `SQ_LOAD`: a serial load that takes an arbitrary seed one bit per clock.

When the warm-up or the load has finished, the sequencer moves to `SQ_RUN` and stays there until the next reset. The named transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| reset entry | any | `SQ_RUN`, `SQ_WARM` or `SQ_LOAD` | chosen by the mode input |
| warm done | `SQ_WARM` | `SQ_RUN` | counter reaches `WARM_CYC-1` |
| load done | `SQ_LOAD` | `SQ_RUN` | counter reaches `STATE_W-1` |

The valid flag is high only in `SQ_RUN`.

Top module: `prng_seeded`

## Requirements
- R1: While reset is high, every state bit is set to one at the same time. The first output byte after reset is therefore 0xFF.
- R2: The mode input is sampled on the last reset clock, with this encoding:
  - 2'b00 and 2'b11 select immediate run. Valid is high from the first clock after reset.
  - 2'b01 selects warm-up.
  - 2'b10 selects serial load.
- R3: In warm-up, a constant one is shifted in for `WARM_CYC` clocks (default 6) after reset is released. Valid is low for exactly those clocks, and the output is 0xFF when valid rises.
- R4: In serial load, `ser_i` is shifted into bit 0 of the state for `STATE_W` clocks after reset is released, so the seed arrives MSB first. Valid rises after the last bit, and the output then equals the seed's low byte.
- R5: A serial seed of all zeros is replaced by all ones, so the all-zero state is never reached.
- R6: `en_i` has no effect while warm-up or serial load is in progress. Both the timing of valid and the resulting state are unchanged by it.
- R7: Each enabled clock in run shifts the state left by one. The new bit 0 is the XOR of state bits 15, 13, 12 and 10. The output `data_o` is state bits 7..0.
- R8: In run with `en_i` low, the state and the output hold.
- R9: Starting from all ones, the sequence has period 2^16 − 1 and repeats exactly from the same initial state.
- R10: Once valid is high, it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high; sets all state bits |
| en_i | input | 1 | Advance enable, honoured only in run |
| mode_i | input | 2 | Seeding mode, sampled during reset |
| ser_i | input | 1 | Serial seed bit, MSB first during serial load |
| data_o | output | 8 | Low byte of the LFSR state |
| valid_o | output | 1 | High when seeding has finished |

## Verification
The assertions assume that `mode_i` is stable during the last reset clock and that reset is synchronous and lasts at least one clock. They also assume that `ser_i` carries real seed bits only while valid is low after a serial-load reset. The stimulus changes inputs only just after a rising edge. It holds `mode_i` throughout each reset pulse and feeds seed bits only during the load window. Enable is randomized freely, including during seeding, because the block must ignore it there.

// File: rtl/prng_pkg.sv
package prng_pkg;

    typedef enum logic [1:0] {
        SQ_WARM = 2'd0,
        SQ_LOAD = 2'd1,
        SQ_RUN  = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        LF_HOLD      = 3'd0,
        LF_STEP      = 3'd1,
        LF_FILL_ONE  = 3'd2,
        LF_FILL_SER  = 3'd3,
        LF_FILL_LAST = 3'd4
    } lfsr_op_t;

    localparam logic [1:0] MODE_WARM = 2'b01;
    localparam logic [1:0] MODE_LOAD = 2'b10;

endpackage

// File: rtl/prng_feedback.sv
module prng_feedback #(
    parameter int              STATE_W  = 16,
    parameter logic [STATE_W-1:0] TAP_MASK = 16'hB400
) (
    input  logic [STATE_W-1:0] state_i,
    output logic               fb_o
);
    logic [STATE_W:0] acc;

    assign acc[0] = 1'b0;

    for (genvar i = 0; i < STATE_W; i++) begin : g_tap
        if (TAP_MASK[i]) begin : g_use
            assign acc[i+1] = acc[i] ^ state_i[i];
        end else begin : g_skip
            assign acc[i+1] = acc[i];
        end
    end

    assign fb_o = acc[STATE_W];
endmodule

// File: rtl/prng_seq_fsm.sv
module prng_seq_fsm
    import prng_pkg::*;
#(
    parameter int STATE_W  = 16,
    parameter int WARM_CYC = 6
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     en_i,
    input  logic [1:0] mode_i,
    output lfsr_op_t op_o,
    output logic     valid_o
);
    localparam int SEED_MAX = (WARM_CYC > STATE_W) ? WARM_CYC : STATE_W;
    localparam int CNT_W    = $clog2(SEED_MAX + 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_CYC - 1);
    localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(STATE_W - 1);

    seq_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_WARM: if (cnt_q == WARM_LAST) state_d = SQ_RUN;
            SQ_LOAD: if (cnt_q == LOAD_LAST) state_d = SQ_RUN;
            SQ_RUN:  state_d = SQ_RUN;
            default: state_d = SQ_RUN;
        endcase
    end

    // state register and seeding counter
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            unique case (mode_i)
                MODE_WARM: state_q <= SQ_WARM;
                MODE_LOAD: state_q <= SQ_LOAD;
                default:   state_q <= SQ_RUN;
            endcase
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == SQ_RUN) ? '0 : cnt_q + 1'b1;
        end
    end

    // outputs per state
    always_comb begin
        op_o    = LF_HOLD;
        valid_o = 1'b0;
        unique case (state_q)
            SQ_WARM: op_o = LF_FILL_ONE;
            SQ_LOAD: op_o = (cnt_q == LOAD_LAST) ? LF_FILL_LAST : LF_FILL_SER;
            SQ_RUN: begin
                op_o    = en_i ? LF_STEP : LF_HOLD;
                valid_o = 1'b1;
            end
            default: op_o = LF_HOLD;
        endcase
    end
endmodule

// File: rtl/prng_lfsr_core.sv
module prng_lfsr_core
    import prng_pkg::*;
#(
    parameter int                 STATE_W  = 16,
    parameter logic [STATE_W-1:0] TAP_MASK = 16'hB400
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  lfsr_op_t           op_i,
    input  logic               ser_i,
    output logic [STATE_W-1:0] state_o
);
    logic [STATE_W-1:0] state_q, state_d, shift_in;
    logic               fb, in_bit;

    prng_feedback #(.STATE_W(STATE_W), .TAP_MASK(TAP_MASK)) u_fb (
        .state_i (state_q),
        .fb_o    (fb)
    );

    always_comb begin
        unique case (op_i)
            LF_STEP:                   in_bit = fb;
            LF_FILL_ONE:               in_bit = 1'b1;
            LF_FILL_SER, LF_FILL_LAST: in_bit = ser_i;
            default:                   in_bit = 1'b0;
        endcase
        shift_in = {state_q[STATE_W-2:0], in_bit};
    end

    always_comb begin
        state_d = state_q;
        unique case (op_i)
            LF_HOLD:      state_d = state_q;
            LF_STEP,
            LF_FILL_ONE,
            LF_FILL_SER:  state_d = shift_in;
            LF_FILL_LAST: state_d = (shift_in == '0) ? '1 : shift_in;
            default:      state_d = state_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '1;
        else       state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/prng_seeded.sv
module prng_seeded
    import prng_pkg::*;
#(
    parameter int                 STATE_W  = 16,
    parameter logic [STATE_W-1:0] TAP_MASK = 16'hB400,
    parameter int                 WARM_CYC = 6,
    parameter int                 OUT_W    = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic             ser_i,
    output logic [OUT_W-1:0] data_o,
    output logic             valid_o
);
    lfsr_op_t           op;
    logic [STATE_W-1:0] lfsr_state;

    prng_seq_fsm #(.STATE_W(STATE_W), .WARM_CYC(WARM_CYC)) u_fsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .mode_i  (mode_i),
        .op_o    (op),
        .valid_o (valid_o)
    );

    prng_lfsr_core #(.STATE_W(STATE_W), .TAP_MASK(TAP_MASK)) u_core (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .op_i    (op),
        .ser_i   (ser_i),
        .state_o (lfsr_state)
    );

    assign data_o = lfsr_state[OUT_W-1:0];
endmodule

// File: rtl/prng_seeded_chk.sv
module prng_seeded_chk #(
    parameter int STATE_W  = 16,
    parameter int OUT_W    = 8,
    parameter int SEED_MAX = 16
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               en_i,
    input logic [1:0]         mode_i,
    input logic [OUT_W-1:0]   data_o,
    input logic               valid_o,
    input logic [STATE_W-1:0] state_i
);
    logic [31:0] idle_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)         idle_q <= '0;
        else if (!valid_o) idle_q <= idle_q + 1;
    end

    assert_reset_ones_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> data_o == {OUT_W{1'b1}});

    assert_run_mode_valid_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(rst_i) && ($past(mode_i) == 2'b00 || $past(mode_i) == 2'b11)) |-> valid_o);

    assert_seed_window_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_o |-> idle_q < SEED_MAX);

    assert_no_zero_state_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> state_i != '0);

    assert_shift_order_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && en_i) |=> data_o[OUT_W-1:1] == $past(data_o[OUT_W-2:0]));

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && !en_i) |=> $stable(data_o));

    assert_valid_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> valid_o);
endmodule

bind prng_seeded prng_seeded_chk #(
    .STATE_W  (STATE_W),
    .OUT_W    (OUT_W),
    .SEED_MAX ((WARM_CYC > STATE_W) ? WARM_CYC : STATE_W)
) i_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .mode_i  (mode_i),
    .data_o  (data_o),
    .valid_o (valid_o),
    .state_i (u_core.state_q)
);

// File: tb/test_prng_seeded.sv
module test_prng_seeded;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 16;
    localparam int WARM = 6;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       en_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       ser_i = 1'b0;
    logic [7:0] data_o;
    logic       valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    prng_seeded i_prng_seeded (
        .clk_i(clk), .rst_i(rst_i), .en_i(en_i), .mode_i(mode_i),
        .ser_i(ser_i), .data_o(data_o), .valid_o(valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cycles++;
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_i  = 1'b1;
        mode_i = m;
        tick();
        tick();
        rst_i  = 1'b0;
        mode_i = 2'(($urandom & 3));
    endtask

    // Run n random-enable steps from model state s, counting mismatches.
    task automatic run_cmp(inout logic [15:0] s, input int n, output int bad);
        bad = 0;
        for (int k = 0; k < n; k++) begin
            logic e;
            e = 1'($urandom & 1);
            en_i = e;
            tick();
            if (e) s = model_step(s);
            if (data_o !== s[7:0] || valid_o !== 1'b1) bad++;
        end
        en_i = 1'b0;
    endtask

    task automatic serial_seed(input logic [15:0] seed, output bit early_valid);
        early_valid = 0;
        for (int b = W - 1; b >= 0; b--) begin
            ser_i = seed[b];
            en_i  = 1'($urandom & 1);
            if (valid_o) early_valid = 1;
            tick();
        end
        ser_i = 1'b0;
        en_i  = 1'b0;
    endtask

    initial begin
        tick();
        forever begin
            @(posedge clk);
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected<=150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [15:0] s;
        int          bad;
        bit          early;
        logic [7:0]  first_run[32];
        void'($urandom(32'h5EED_1234));

        // R1, R2: immediate run mode
        do_reset(2'b00);
        check(data_o === 8'hFF, "R1 first byte after reset", data_o, 8'hFF);
        check(valid_o === 1'b1, "R2 mode 00 valid at once", valid_o, 1);
        do_reset(2'b11);
        check(valid_o === 1'b1, "R2 mode 11 valid at once", valid_o, 1);

        // R7: directed steps from all ones with enable held high
        s = 16'hFFFF;
        en_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            s = model_step(s);
        end
        en_i = 1'b0;
        check(data_o === s[7:0], "R7 four steps from ones", data_o, s[7:0]);

        // R8: hold with enable low
        for (int k = 0; k < 5; k++) tick();
        check(data_o === s[7:0], "R8 hold with en low", data_o, s[7:0]);

        // R7, R8: random enable pattern
        run_cmp(s, 300, bad);
        check(bad == 0, "R7 R8 random enable run", bad, 0);

        // R1: reset in mid-run restores ones
        do_reset(2'b00);
        check(data_o === 8'hFF, "R1 reset during run", data_o, 8'hFF);

        // R3, R6: warm-up with random enable
        do_reset(2'b01);
        check(valid_o === 1'b0, "R3 warm-up valid low", valid_o, 0);
        for (int k = 0; k < WARM - 1; k++) begin
            en_i = 1'($urandom & 1);
            tick();
        end
        check(valid_o === 1'b0, "R3 R6 valid still low one cycle early", valid_o, 0);
        en_i = 1'b1;
        tick();
        en_i = 1'b0;
        check(valid_o === 1'b1, "R3 valid after warm-up cycles", valid_o, 1);
        check(data_o === 8'hFF, "R3 R6 warm-up leaves ones", data_o, 8'hFF);
        s = 16'hFFFF;
        run_cmp(s, 100, bad);
        check(bad == 0, "R3 sequence after warm-up", bad, 0);

        // R4, R6: serial seeds (directed and random)
        for (int t = 0; t < 6; t++) begin
            logic [15:0] seed;
            seed = (t == 0) ? 16'h0001 : (t == 1) ? 16'h8000 : 16'($urandom);
            if (seed == 16'h0) seed = 16'hACE1;
            do_reset(2'b10);
            serial_seed(seed, early);
            check(!early, "R4 R6 valid low during load", early, 0);
            check(valid_o === 1'b1, "R4 valid after load", valid_o, 1);
            check(data_o === seed[7:0], "R4 loaded low byte", data_o, seed[7:0]);
            s = seed;
            run_cmp(s, 200, bad);
            check(bad == 0, "R4 R7 sequence from loaded seed", bad, 0);
        end

        // R5: zero seed replaced by ones
        do_reset(2'b10);
        serial_seed(16'h0000, early);
        check(valid_o === 1'b1, "R5 valid after zero seed", valid_o, 1);
        check(data_o === 8'hFF, "R5 zero seed becomes ones", data_o, 8'hFF);
        s = 16'hFFFF;
        run_cmp(s, 50, bad);
        check(bad == 0, "R5 sequence after zero seed", bad, 0);

        // R9: determinism, two runs from ones
        do_reset(2'b00);
        en_i = 1'b1;
        for (int k = 0; k < 32; k++) begin
            tick();
            first_run[k] = data_o;
        end
        do_reset(2'b00);
        en_i = 1'b1;
        bad = 0;
        for (int k = 0; k < 32; k++) begin
            tick();
            if (data_o !== first_run[k]) bad++;
        end
        check(bad == 0, "R9 repeat from same state", bad, 0);

        // R9: full period
        do_reset(2'b00);
        s = 16'hFFFF;
        en_i = 1'b1;
        bad = 0;
        for (int k = 1; k <= 65535; k++) begin
            tick();
            s = model_step(s);
            if (data_o !== s[7:0]) bad++;
            if (k < 65535 && s == 16'hFFFF) bad++;
        end
        en_i = 1'b0;
        check(bad == 0, "R9 sequence over full period", bad, 0);
        check(s == 16'hFFFF && data_o === 8'hFF, "R9 returns to start after 2^16-1",
              data_o, 8'hFF);
        check(valid_o === 1'b1, "R10 valid still high", valid_o, 1);

        finish_run();
    end
endmodule